// File: doc/BRIEF.md
# Word-Packed SPI Byte Buffer

This block sits between a 32-bit register port and a byte-serial SPI shift engine. It holds two independent 32-byte queues. Software writes transmit data one 32-bit word at a time. The block splits each word into bytes and hands them to the shifter over a valid/ready handshake. Bytes that the shifter receives enter a second queue. Software reads them back as 32-bit words, which the block assembles from the queued bytes.

Each direction has its own byte-order control. With the order bit clear, bytes leave or enter a word at the least significant lane first. With the order bit set, they start at the most significant lane. A run length in bytes is loaded before each transfer, and both directions follow it. When that length is not a multiple of four, the last word uses only its low lanes. On the transmit side, the unused upper lanes of that last word are thrown away. On the receive side, the last word is returned with zeros in its upper lanes. Two sticky error flags record a dropped word write and a read that found too few bytes. A software clear empties both queues and clears both flags.

Top module: `spi_wpack_fifo`

## Requirements
- R1: After reset, `tx_valid` is 0, `rx_ready` is 1, `ovf_flag` and `udf_flag` are 0, and `rd_data` is 0.
- R2: With `tx_msb_first`=0, an accepted word is sent as four bytes in the order bits [7:0], [15:8], [23:16], [31:24].
- R3: With `tx_msb_first`=1, an accepted word is sent as four bytes in the order bits [31:24], [23:16], [15:8], [7:0].
- R4: A word write takes min(4, bytes left in the run) bytes, always from the low lanes. With `tx_msb_first`=1 and n bytes taken, lane n-1 goes first and lane 0 goes last. A write made after the run is used up adds no bytes.
- R5: With `rx_msb_first`=0, a read returns a full word whose first received byte is in bits [7:0] and whose fourth received byte is in bits [31:24].
- R6: With `rx_msb_first`=1, a read returns a full word whose first received byte is in bits [31:24].
- R7: When k<4 bytes are left in the run, a read packs those k bytes into lanes 0..k-1 and sets the upper lanes to zero. With `rx_msb_first`=1, the first of those bytes goes in lane k-1.
- R8: Each direction holds 32 bytes. A word write that finds fewer than 4 free transmit slots is dropped and sets `ovf_flag`, and the bytes already queued are left as they were. `rx_ready` is 0 while 32 received bytes are held.
- R9: A read needs min(4, bytes left in the run) bytes to be present and that count to be nonzero. If either condition fails, the read returns 0, sets `udf_flag`, and removes no bytes.
- R10: A `soft_clear` pulse empties both queues, clears the run count, and clears both flags. `rx_ready` is 1 again on the next cycle.
- R11: Once set, `ovf_flag` and `udf_flag` stay set until `soft_clear`.
- R12: A transmit byte leaves only on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_byte` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clear | input | 1 | Empties both queues and clears the run count and the flags |
| tx_msb_first | input | 1 | Transmit byte order: 1 sends the most significant lane first |
| rx_msb_first | input | 1 | Receive byte order: 1 places the first byte in the most significant lane |
| run_load | input | 1 | Loads `run_bytes` as the remaining count for both directions |
| run_bytes | input | 6 | Run length in bytes |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | 32 | Word to transmit |
| rd_en | input | 1 | Word read strobe |
| rd_data | output | 32 | Read result, registered, valid on the cycle after `rd_en` |
| tx_valid | output | 1 | A transmit byte is available |
| tx_byte | output | 8 | Transmit byte at the head of the queue |
| tx_ready | input | 1 | Shifter accepts the transmit byte |
| rx_valid | input | 1 | Shifter offers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Receive queue has room for a byte |
| ovf_flag | output | 1 | Sticky flag: a word write was dropped |
| udf_flag | output | 1 | Sticky flag: a read found too few bytes |

## Verification
The embedded properties check every cycle that both flags stay set, that a clear leaves both queues empty, that a dropped write leaves the transmit level unchanged apart from a byte leaving, that a stalled head byte does not change, and that queue levels stay in range. Properties cannot capture lane order for either byte-order setting, partial-word placement, or the run count that cuts off the transmit stream. The scoreboard shows these by comparing every byte and word against values predicted from the run length and the order bits.

// File: rtl/spi_wpack_pkg.sv
// Package: shared widths for the word-packed SPI byte buffer.
// Assumes a 32-bit software word split into 8-bit byte lanes.
package spi_wpack_pkg;
    localparam int LANE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = LANE_W * WORD_BYTES;
    localparam int SEL_W      = $clog2(WORD_BYTES);
    localparam int KCNT_W     = $clog2(WORD_BYTES + 1);

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [KCNT_W-1:0] kcnt_t;
endpackage

// File: rtl/spi_wpack_ring.sv
// Module: circular byte store with a multi-byte push port and a multi-byte
// peek/pop port. Up to IN_W bytes go in and up to OUT_W bytes come out in a
// single cycle.
// Assumes: DEPTH is a power of two, and the caller never pushes past free
// space or pops more than the level.
module spi_wpack_ring #(
    parameter int DEPTH = 32,
    parameter int IN_W  = 4,
    parameter int OUT_W = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic [$clog2(IN_W+1)-1:0]    push_cnt,
    input  logic [IN_W*8-1:0]            push_data,
    input  logic [$clog2(OUT_W+1)-1:0]   pop_cnt,
    output logic [OUT_W*8-1:0]           peek_data,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Byte storage: write the accepted lanes at consecutive slots from the tail.
    always_ff @(posedge clk) begin : store_bytes
        for (int i = 0; i < IN_W; i++) begin
            if (i < int'(push_cnt)) begin
                mem[wr_ptr + AW'(i)] <= push_data[i*8 +: 8];
            end
        end
    end

    // Pointer and level bookkeeping; both a reset and a clear empty the store.
    always_ff @(posedge clk) begin : move_ptrs
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_cnt);
            rd_ptr <= rd_ptr + AW'(pop_cnt);
            level  <= level + CW'(push_cnt) - CW'(pop_cnt);
        end
    end

    // Peek lanes: the oldest OUT_W bytes starting at the head.
    for (genvar j = 0; j < OUT_W; j++) begin : g_peek
        logic [AW-1:0] ridx;
        assign ridx = rd_ptr + AW'(j);
        assign peek_data[j*8 +: 8] = mem[ridx];
    end

    // The level never goes above the capacity.
    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // The caller never removes more bytes than are stored.
    assert_no_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_cnt) <= level);
endmodule

// File: rtl/spi_wpack_unpack.sv
// Module: orders the bytes of a software word into send order.
// Output lane i is the i-th byte to send. With msb_first set and cnt bytes
// valid, lane cnt-1 is sent first. Lanes at or above cnt are don't-care.
// Assumes: cnt is at most WORD_BYTES.
module spi_wpack_unpack
    import spi_wpack_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  kcnt_t             cnt,
    input  logic              msb_first,
    output logic [WORD_W-1:0] ordered
);
    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
        logic [SEL_W-1:0] src;
        // Source lane for output position i.
        assign src = msb_first ? SEL_W'(cnt - KCNT_W'(i) - KCNT_W'(1)) : SEL_W'(i);
        assign ordered[i*LANE_W +: LANE_W] = word[src*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/spi_wpack_pack.sv
// Module: builds a software word from bytes given in arrival order.
// Only the low cnt lanes are filled; the lanes above them read as zero.
// With msb_first set, the first byte lands in lane cnt-1.
// Assumes: cnt is at most WORD_BYTES.
module spi_wpack_pack
    import spi_wpack_pkg::*;
(
    input  logic [WORD_W-1:0] arrived,
    input  kcnt_t             cnt,
    input  logic              msb_first,
    output logic [WORD_W-1:0] word
);
    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        logic [SEL_W-1:0] src;
        logic             used;
        // Select the arrival slot that feeds word lane l.
        assign src  = msb_first ? SEL_W'(cnt - KCNT_W'(l) - KCNT_W'(1)) : SEL_W'(l);
        assign used = KCNT_W'(l) < cnt;
        assign word[l*LANE_W +: LANE_W] = used ? arrived[src*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/spi_wpack_fifo.sv
// Module: top of the word-packed SPI byte buffer. It contains a transmit
// queue that splits words into bytes for the shifter and a receive queue
// that joins shifter bytes into words. A per-run byte count limits both
// directions.
// Assumes: run_load is not asserted in the same cycle as wr_en or rd_en.
module spi_wpack_fifo
    import spi_wpack_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        soft_clear,
    input  logic                        tx_msb_first,
    input  logic                        rx_msb_first,
    input  logic                        run_load,
    input  logic [$clog2(DEPTH+1)-1:0]  run_bytes,
    input  logic                        wr_en,
    input  logic [31:0]                 wr_data,
    input  logic                        rd_en,
    output logic [31:0]                 rd_data,
    output logic                        tx_valid,
    output logic [7:0]                  tx_byte,
    input  logic                        tx_ready,
    input  logic                        rx_valid,
    input  logic [7:0]                  rx_byte,
    output logic                        rx_ready,
    output logic                        ovf_flag,
    output logic                        udf_flag
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]     tx_left, rx_left, tx_level, rx_level, tx_space;
    kcnt_t             tx_take, rx_take, tx_push_cnt, rx_pop_cnt;
    logic              wr_fits, tx_pop, rx_push, rd_ok;
    logic [WORD_W-1:0] tx_ordered, rx_arrived, rx_word;

    // Transmit side: a word is admitted only if four slots are free.
    assign tx_space    = CW'(DEPTH) - tx_level;
    assign wr_fits     = tx_space >= CW'(WORD_BYTES);
    assign tx_take     = (tx_left >= CW'(WORD_BYTES)) ? KCNT_W'(WORD_BYTES) : KCNT_W'(tx_left);
    assign tx_push_cnt = (wr_en && wr_fits) ? tx_take : '0;
    assign tx_valid    = tx_level != '0;
    assign tx_pop      = tx_valid && tx_ready;

    // Receive side: a read needs the full remaining slice of the run present.
    assign rx_ready    = rx_level < CW'(DEPTH);
    assign rx_push     = rx_valid && rx_ready;
    assign rx_take     = (rx_left >= CW'(WORD_BYTES)) ? KCNT_W'(WORD_BYTES) : KCNT_W'(rx_left);
    assign rd_ok       = rd_en && (rx_take != '0) && (rx_level >= CW'(rx_take));
    assign rx_pop_cnt  = rd_ok ? rx_take : '0;

    spi_wpack_unpack u_unpack (
        .word      (wr_data),
        .cnt       (tx_take),
        .msb_first (tx_msb_first),
        .ordered   (tx_ordered)
    );

    spi_wpack_ring #(.DEPTH(DEPTH), .IN_W(WORD_BYTES), .OUT_W(1)) u_tx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (soft_clear),
        .push_cnt  (tx_push_cnt),
        .push_data (tx_ordered),
        .pop_cnt   (tx_pop),
        .peek_data (tx_byte),
        .level     (tx_level)
    );

    spi_wpack_ring #(.DEPTH(DEPTH), .IN_W(1), .OUT_W(WORD_BYTES)) u_rx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (soft_clear),
        .push_cnt  (rx_push),
        .push_data (rx_byte),
        .pop_cnt   (rx_pop_cnt),
        .peek_data (rx_arrived),
        .level     (rx_level)
    );

    spi_wpack_pack u_pack (
        .arrived   (rx_arrived),
        .cnt       (rx_take),
        .msb_first (rx_msb_first),
        .word      (rx_word)
    );

    // Run counters: loaded per run, reduced by the bytes each direction consumes.
    always_ff @(posedge clk) begin : run_count
        if (!rst_n || soft_clear) begin
            tx_left <= '0;
            rx_left <= '0;
        end else if (run_load) begin
            tx_left <= run_bytes;
            rx_left <= run_bytes;
        end else begin
            tx_left <= tx_left - CW'(tx_push_cnt);
            rx_left <= rx_left - CW'(rx_pop_cnt);
        end
    end

    // Sticky error flags, cleared only by reset or soft_clear.
    always_ff @(posedge clk) begin : err_flags
        if (!rst_n || soft_clear) begin
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            if (wr_en && !wr_fits) ovf_flag <= 1'b1;
            if (rd_en && !rd_ok)   udf_flag <= 1'b1;
        end
    end

    // Read data register: the packed word, or zero if the read failed.
    always_ff @(posedge clk) begin : read_reg
        if (!rst_n || soft_clear) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_ok ? rx_word : '0;
        end
    end

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !soft_clear) |=> ovf_flag);

    assert_udf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_flag && !soft_clear) |=> udf_flag);

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clear |=> (!tx_valid && rx_ready && rx_level == '0 && !ovf_flag && !udf_flag));

    assert_drop_keeps_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_fits && !soft_clear) |=> (tx_level == $past(tx_level) - CW'($past(tx_pop))));

    assert_stall_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !soft_clear) |=> (tx_valid && $stable(tx_byte)));

    assert_empty_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rx_level == '0 && !soft_clear) |=> (rd_data == '0 && udf_flag));
endmodule

// File: tb/spi_wpack_fifo_bench.sv
module spi_wpack_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n, soft_clear, tx_msb_first, rx_msb_first, run_load;
    logic [5:0]  run_bytes;
    logic        wr_en, rd_en, tx_ready, rx_valid;
    logic [31:0] wr_data, rd_data;
    logic [7:0]  tx_byte, rx_byte;
    logic        tx_valid, rx_ready, ovf_flag, udf_flag;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    string cur_req = "R2";
    int tb_tx_left = 0;
    logic [7:0]  tx_q[$];
    logic [31:0] rx_q[$];
    logic        rd_chk = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    spi_wpack_fifo u_spi_wpack_fifo (
        .clk(clk), .rst_n(rst_n), .soft_clear(soft_clear),
        .tx_msb_first(tx_msb_first), .rx_msb_first(rx_msb_first),
        .run_load(run_load), .run_bytes(run_bytes),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic load_run(input int n);
        step(); run_load = 1'b1; run_bytes = 6'(n);
        step(); run_load = 1'b0;
        tb_tx_left = n;
    endtask

    task automatic clear_all();
        step(); soft_clear = 1'b1;
        step(); soft_clear = 1'b0;
        tb_tx_left = 0;
    endtask

    // Driver: writes a word and queues the bytes the requirements predict.
    task automatic put_word(input logic [31:0] w, input bit emitted);
        int n;
        n = (tb_tx_left > 4) ? 4 : tb_tx_left;
        if (emitted) begin
            for (int i = 0; i < n; i++) begin
                int lane;
                lane = tx_msb_first ? (n - 1 - i) : i;
                tx_q.push_back(w[lane*8 +: 8]);
            end
            tb_tx_left -= n;
        end
        step(); wr_en = 1'b1; wr_data = w;
        step(); wr_en = 1'b0;
    endtask

    task automatic put_rx(input logic [7:0] b);
        step(); rx_valid = 1'b1; rx_byte = b;
        step(); rx_valid = 1'b0;
    endtask

    task automatic get_word(input logic [31:0] exp);
        rx_q.push_back(exp);
        step(); rd_en = 1'b1;
        step(); rd_en = 1'b0;
    endtask

    task automatic drain();
        while (tx_q.size() != 0) step();
        repeat (3) step();
    endtask

    // Monitor: compares bytes handed over and words read back.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (tx_q.size() == 0) chk("R12 unexpected byte", {24'h0, tx_byte}, 32'hxxxxxxxx);
                else chk(cur_req, {24'h0, tx_byte}, {24'h0, tx_q.pop_front()});
            end
            if (rd_chk) begin
                if (rx_q.size() == 0) chk("R9 unexpected read", rd_data, 32'hxxxxxxxx);
                else chk(cur_req, rd_data, rx_q.pop_front());
            end
            rd_chk = rd_en;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; soft_clear = 1'b0; tx_msb_first = 1'b0; rx_msb_first = 1'b0;
        run_load = 1'b0; run_bytes = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        tx_ready = 1'b1; rx_valid = 1'b0; rx_byte = '0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_valid", {31'h0, tx_valid}, 0);
        chk("R1 rx_ready", {31'h0, rx_ready}, 1);
        chk("R1 flags", {30'h0, ovf_flag, udf_flag}, 0);
        chk("R1 rd_data", rd_data, 0);

        // R2 least significant lane first
        cur_req = "R2"; tx_msb_first = 1'b0; load_run(8);
        put_word(32'h44332211, 1); put_word(32'h88776655, 1); drain();

        // R3 most significant lane first
        cur_req = "R3"; tx_msb_first = 1'b1; load_run(8);
        put_word(32'hA1B2C3D4, 1); put_word(32'h0F1E2D3C, 1); drain();

        // R4 partial final word, then a write past the run end
        cur_req = "R4"; load_run(6);
        put_word(32'h03020100, 1); put_word(32'hFFFF5A6B, 1); put_word(32'h99999999, 1);
        drain();
        chk("R4 nothing after run", {31'h0, tx_valid}, 0);
        chk("R4 no overflow", {31'h0, ovf_flag}, 0);
        tx_msb_first = 1'b0; load_run(3);
        put_word(32'hDDCCBBAA, 1); drain();

        // R12 stall holds head byte
        cur_req = "R12"; tx_ready = 1'b0; load_run(4);
        put_word(32'h0D0C0B0A, 1);
        @(negedge clk);
        chk("R12 valid while stalled", {31'h0, tx_valid}, 1);
        chk("R12 head byte", {24'h0, tx_byte}, 32'h0A);
        repeat (3) step();
        @(negedge clk);
        chk("R12 head stable", {24'h0, tx_byte}, 32'h0A);
        step(); tx_ready = 1'b1; drain();

        // R8 capacity and dropped ninth word
        cur_req = "R8"; tx_ready = 1'b0; load_run(32);
        for (int i = 0; i < 8; i++) put_word({4{8'(i * 16 + 1)}} + 32'h00010203, 1);
        put_word(32'hEEEEEEEE, 0);
        @(negedge clk);
        chk("R8 overflow flag", {31'h0, ovf_flag}, 1);
        step(); tx_ready = 1'b1; drain();
        chk("R11 overflow sticky", {31'h0, ovf_flag}, 1);
        clear_all();
        @(negedge clk);
        chk("R10 overflow cleared", {31'h0, ovf_flag}, 0);

        // R10 clear empties transmit queue
        tx_ready = 1'b0; load_run(8);
        put_word(32'h12345678, 0); put_word(32'h9ABCDEF0, 0);
        clear_all();
        tx_ready = 1'b1; repeat (4) step();
        @(negedge clk);
        chk("R10 tx emptied", {31'h0, tx_valid}, 0);

        // R5 receive least significant first
        cur_req = "R5"; rx_msb_first = 1'b0; load_run(8);
        for (int i = 0; i < 8; i++) put_rx(8'h10 + 8'(i));
        get_word(32'h13121110); get_word(32'h17161514);

        // R6 receive most significant first
        cur_req = "R6"; rx_msb_first = 1'b1; load_run(4);
        for (int i = 0; i < 4; i++) put_rx(8'hA0 + 8'(i));
        get_word(32'hA0A1A2A3);

        // R7 partial final word in both orders
        cur_req = "R7"; load_run(6);
        for (int i = 1; i <= 6; i++) put_rx(8'(i));
        get_word(32'h01020304); get_word(32'h00000506);
        rx_msb_first = 1'b0; load_run(3);
        put_rx(8'h07); put_rx(8'h08); put_rx(8'h09);
        get_word(32'h00090807);
        step();
        @(negedge clk);
        chk("R9 no stray flag", {31'h0, udf_flag}, 0);

        // R9 short read returns zero and removes nothing
        cur_req = "R9"; load_run(4);
        put_rx(8'h21); put_rx(8'h22);
        get_word(32'h0);
        @(negedge clk);
        chk("R9 underflow flag", {31'h0, udf_flag}, 1);
        put_rx(8'h23); put_rx(8'h24);
        get_word(32'h24232221);
        @(negedge clk);
        chk("R11 underflow sticky", {31'h0, udf_flag}, 1);
        clear_all();

        // R8 receive capacity, then R10 clear
        load_run(32);
        for (int i = 0; i < 32; i++) put_rx(8'(i));
        @(negedge clk);
        chk("R8 rx_ready low when full", {31'h0, rx_ready}, 0);
        clear_all();
        @(negedge clk);
        chk("R10 rx_ready after clear", {31'h0, rx_ready}, 1);
        chk("R10 underflow cleared", {31'h0, udf_flag}, 0);
        cur_req = "R10"; get_word(32'h0);
        repeat (2) step();

        chk("R2 tx queue consumed", tx_q.size(), 0);
        chk("R5 rx queue consumed", rx_q.size(), 0);
        summary();
    end
endmodule